// File: doc/BRIEF.md
# Hot-Plug Slot Status Register

This block holds the 16-bit status word of a hot-pluggable downstream port. It watches the slot's sideband wires (attention button, power fault, retention latch sensor and card presence, all active-low), an interlock status wire, a one-cycle command-completed pulse from the controller and the link-active level from the link layer. Change events are caught in sticky flags that software clears by writing 1. The live levels of the latch, the presence and the interlock are shown in read-only bits.

Software reads the word on `rd_data`, which always shows the current register contents. It writes with a one-cycle `wr_en` strobe and `wr_data`. Every 1 in `wr_data` clears the matching flag, and every 0 leaves its flag alone. Parameters remove features a port does not have. A flag for a missing feature never sets. A port with no slot reports a card as present.

Bit layout of `rd_data`: 0 attention press, 1 power fault, 2 latch changed, 3 presence changed, 4 command done, 5 latch level, 6 card present, 7 interlock engaged, 8 link-active changed, 9 to 15 zero.

Top module: `hp_slot_status`

## Requirements
- R1: While reset is asserted and after it is released, flags 0 to 4 and 8 read 0, even when the sideband inputs already sit at their asserted levels during reset.
- R2: Bit 0 sets only when `attn_n` falls from 1 to 0. It appears 3 clock edges after the input changes. A rise of `attn_n` never sets it.
- R3: Bit 1 sets when `pfault_n` falls from 1 to 0, with the same 3-edge latency.
- R4: Bit 2 sets on every change of `latch_n`, both rising and falling, 3 edges after the change.
- R5: Bit 3 sets on every change of `pres_n`, both rising and falling, 3 edges after the change.
- R6: Bit 4 sets one edge after a clock cycle in which `cmd_done` is 1.
- R7: Bit 8 sets one edge after any change of `link_up`, rising or falling.
- R8: A write with `wr_en` high clears every flag whose `wr_data` bit is 1, one edge later. Flags whose `wr_data` bit is 0 keep their value.
- R9: If a flag's event and a write-1 clear of that flag fall in the same cycle, the flag is 1 after that edge.
- R10: Bit 5 equals `latch_n` (1 means open). Bit 6 equals the inverse of `pres_n` (1 means a card is present). Bit 7 equals `lock_in` (1 means engaged). Each follows its input 2 edges after the change.
- R11: Bits 9 to 15 always read 0, including after a write of all ones.
- R12: With a feature parameter at 0, its flag never sets and its level bit reads 0. This covers the attention button (bit 0), power fault (bit 1), latch sensor (bits 2 and 5), command completion (bit 4) and interlock (bit 7). With `HAS_SLOT` at 0, bit 3 never sets and bit 6 reads 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| attn_n | input | 1 | Attention button, active-low, asynchronous |
| pfault_n | input | 1 | Power fault, active-low, asynchronous |
| latch_n | input | 1 | Retention latch sensor, 1 = open, asynchronous |
| pres_n | input | 1 | Card presence, active-low, asynchronous |
| lock_in | input | 1 | Interlock status, 1 = engaged, asynchronous |
| cmd_done | input | 1 | Command completed pulse, synchronous |
| link_up | input | 1 | Link active level, synchronous |
| wr_en | input | 1 | Write strobe for the status word |
| wr_data | input | 16 | Write data, 1 clears a flag |
| rd_data | output | 16 | Current status word |

## Verification
Each result has a fixed latency from its stimulus. A sideband flag is due 3 clock edges after the input changes: two synchronizer stages, then the flag register. A live level bit is due after 2 edges. The command, link and write effects are due after 1 edge. The driver changes inputs just after a rising edge. At that moment it queues the expected masked value with the cycle it falls due. The monitor compares only at the falling edge of that cycle, and it also checks the cycle before a flag is due to confirm the flag has not yet set. A second instance with every feature removed gets the same stimulus and is checked for flags that must stay at 0.

// File: rtl/hp_slot_pkg.sv
package hp_slot_pkg;

    localparam int STS_W  = 16;
    localparam int NUM_EV = 6;

    // Bit positions software decodes in the status word
    localparam int POS_LATCH_LVL = 5;
    localparam int POS_PRES_LVL  = 6;
    localparam int POS_LOCK_LVL  = 7;
    localparam int POS_TOP_EVENT = 8;

    typedef enum logic [1:0] {
        EDGE_FALL  = 2'd0,
        EDGE_ANY   = 2'd1,
        EDGE_PULSE = 2'd2
    } edge_mode_e;

    typedef struct packed {
        logic lock;
        logic pres_n;
        logic latch_n;
        logic pfault_n;
        logic attn_n;
    } side_t;

    localparam int SIDE_W = $bits(side_t);

    // Event slot index -> rule that sets the flag
    function automatic edge_mode_e ev_mode(input int idx);
        case (idx)
            0, 1:    return EDGE_FALL;
            4:       return EDGE_PULSE;
            default: return EDGE_ANY;
        endcase
    endfunction

    // Event slot index -> bit position in the status word
    function automatic int ev_pos(input int idx);
        return (idx == NUM_EV - 1) ? POS_TOP_EVENT : idx;
    endfunction

    function automatic logic edge_hit(input edge_mode_e m, input logic now, input logic prev);
        case (m)
            EDGE_FALL: return prev & ~now;
            EDGE_ANY:  return prev ^ now;
            default:   return now;
        endcase
    endfunction

endpackage

// File: rtl/hp_sync_bank.sv
module hp_sync_bank #(
    parameter int W      = 5,
    parameter int STAGES = 2
) (
    input  logic         clk,
    input  logic         rst,
    input  logic [W-1:0] din,
    output logic [W-1:0] dout
);
    // Not reset: the chain keeps sampling so levels are settled when reset ends
    logic [W-1:0] stg [STAGES];

    always_ff @(posedge clk) begin
        stg[0] <= din;
        for (int i = 1; i < STAGES; i++) begin
            stg[i] <= stg[i-1];
        end
    end

    assign dout = stg[STAGES-1];

    p_first_stage_r10: assert property (@(posedge clk) disable iff (rst)
        stg[0] == $past(din));

    for (genvar s = 1; s < STAGES; s++) begin : g_chk
        p_stage_shift_r10: assert property (@(posedge clk) disable iff (rst)
            stg[s] == $past(stg[s-1]));
    end

endmodule

// File: rtl/hp_event_flag.sv
module hp_event_flag
    import hp_slot_pkg::*;
#(
    parameter edge_mode_e MODE   = EDGE_ANY,
    parameter bit         ENABLE = 1'b1
) (
    input  logic clk,
    input  logic rst,
    input  logic level,
    input  logic clr,
    output logic flag
);
    localparam logic EN = ENABLE;

    logic hit;

    if (MODE == EDGE_PULSE) begin : g_pulse
        assign hit = level;
    end else begin : g_edge
        logic hist;
        // Loads the present level in reset too, so no false edge after release
        always_ff @(posedge clk) hist <= level;
        assign hit = edge_hit(MODE, level, hist);

        if (MODE == EDGE_FALL) begin : g_fall_chk
            p_fall_only_r2: assert property (@(posedge clk) disable iff (rst)
                $rose(flag) |-> ($past(hist) && !$past(level)));
        end
    end

    // Event wins over a clear arriving in the same cycle
    always_ff @(posedge clk) begin
        if (rst) flag <= 1'b0;
        else     flag <= EN & (hit | (flag & ~clr));
    end

    p_set_on_event_r9: assert property (@(posedge clk) disable iff (rst)
        (EN && hit) |=> flag);

    p_clear_r8: assert property (@(posedge clk) disable iff (rst)
        (clr && !hit) |=> !flag);

    p_hold_r8: assert property (@(posedge clk) disable iff (rst)
        (flag && !clr) |=> flag);

endmodule

// File: rtl/hp_slot_status.sv
module hp_slot_status
    import hp_slot_pkg::*;
#(
    parameter bit HAS_ATTN    = 1'b1,
    parameter bit HAS_PFAULT  = 1'b1,
    parameter bit HAS_LATCH   = 1'b1,
    parameter bit HAS_CMD     = 1'b1,
    parameter bit HAS_LOCK    = 1'b1,
    parameter bit HAS_SLOT    = 1'b1,
    parameter int SYNC_STAGES = 2
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             attn_n,
    input  logic             pfault_n,
    input  logic             latch_n,
    input  logic             pres_n,
    input  logic             lock_in,
    input  logic             cmd_done,
    input  logic             link_up,
    input  logic             wr_en,
    input  logic [STS_W-1:0] wr_data,
    output logic [STS_W-1:0] rd_data
);
    localparam logic [NUM_EV-1:0] EV_EN =
        {1'b1, HAS_CMD, HAS_SLOT, HAS_LATCH, HAS_PFAULT, HAS_ATTN};

    side_t raw, syn;
    logic [SIDE_W-1:0] syn_bits;
    logic [NUM_EV-1:0] ev_lvl;
    logic [NUM_EV-1:0] ev_flag;
    logic [STS_W-1:0]  sts;
    logic              unused_wr;

    assign raw = '{lock: lock_in, pres_n: pres_n, latch_n: latch_n,
                   pfault_n: pfault_n, attn_n: attn_n};

    hp_sync_bank #(.W(SIDE_W), .STAGES(SYNC_STAGES)) u_sync (
        .clk  (clk),
        .rst  (rst),
        .din  (raw),
        .dout (syn_bits)
    );
    assign syn = side_t'(syn_bits);

    assign ev_lvl = {link_up, cmd_done, syn.pres_n, syn.latch_n,
                     syn.pfault_n, syn.attn_n};

    for (genvar i = 0; i < NUM_EV; i++) begin : g_ev
        hp_event_flag #(.MODE(ev_mode(i)), .ENABLE(EV_EN[i])) u_flag (
            .clk   (clk),
            .rst   (rst),
            .level (ev_lvl[i]),
            .clr   (wr_en & wr_data[ev_pos(i)]),
            .flag  (ev_flag[i])
        );
    end

    always_comb begin
        sts = '0;
        for (int i = 0; i < NUM_EV; i++) begin
            sts[ev_pos(i)] = ev_flag[i];
        end
        sts[POS_LATCH_LVL] = HAS_LATCH ? syn.latch_n : 1'b0;
        sts[POS_PRES_LVL]  = HAS_SLOT ? ~syn.pres_n : 1'b1;
        sts[POS_LOCK_LVL]  = HAS_LOCK ? syn.lock : 1'b0;
    end

    assign rd_data   = sts;
    assign unused_wr = ^{wr_data[STS_W-1:POS_TOP_EVENT+1],
                         wr_data[POS_LOCK_LVL:POS_LATCH_LVL]};

endmodule

// File: tb/tb_hp_slot_status.sv
module tb_hp_slot_status;

    localparam int CLK_PERIOD = 10;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        attn_n = 1'b1, pfault_n = 1'b1, latch_n = 1'b0, pres_n = 1'b0;
    logic        lock_in = 1'b1, cmd_done = 1'b0, link_up = 1'b1;
    logic        wr_en = 1'b0;
    logic [15:0] wr_data = '0;
    logic [15:0] rd_full, rd_bare;

    int cyc = 0;
    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    typedef struct {
        int          due;
        bit          bare;
        logic [15:0] mask;
        logic [15:0] val;
        string       tag;
    } exp_t;

    exp_t q[$];
    logic [15:0] got;

    always #(CLK_PERIOD/2) clk = ~clk;
    always @(posedge clk) cyc <= cyc + 1;

    hp_slot_status dut (
        .clk(clk), .rst(rst), .attn_n(attn_n), .pfault_n(pfault_n),
        .latch_n(latch_n), .pres_n(pres_n), .lock_in(lock_in),
        .cmd_done(cmd_done), .link_up(link_up), .wr_en(wr_en),
        .wr_data(wr_data), .rd_data(rd_full)
    );

    hp_slot_status #(
        .HAS_ATTN(1'b0), .HAS_PFAULT(1'b0), .HAS_LATCH(1'b0),
        .HAS_CMD(1'b0), .HAS_LOCK(1'b0), .HAS_SLOT(1'b0)
    ) dut_bare (
        .clk(clk), .rst(rst), .attn_n(attn_n), .pfault_n(pfault_n),
        .latch_n(latch_n), .pres_n(pres_n), .lock_in(lock_in),
        .cmd_done(cmd_done), .link_up(link_up), .wr_en(wr_en),
        .wr_data(wr_data), .rd_data(rd_bare)
    );

    // Monitor: compare every expectation that falls due this cycle
    always @(negedge clk) begin
        for (int i = q.size() - 1; i >= 0; i--) begin
            if (q[i].due == cyc) begin
                got = q[i].bare ? rd_bare : rd_full;
                checks++;
                if ((got & q[i].mask) !== q[i].val) begin
                    errors++;
                    $display("FAIL %s: %s got %h expected %h (mask %h) at cycle %0d",
                             q[i].tag, q[i].bare ? "dut_bare" : "dut",
                             got & q[i].mask, q[i].val, q[i].mask, cyc);
                end
                q.delete(i);
            end
        end
    end

    task automatic step(input int n);
        repeat (n) @(posedge clk);
        #1;
    endtask

    task automatic expect_at(input int dly, input bit bare,
                             input logic [15:0] m, input logic [15:0] v,
                             input string tag);
        exp_t e;
        e.due = cyc + dly; e.bare = bare; e.mask = m; e.val = v; e.tag = tag;
        q.push_back(e);
    endtask

    task automatic write_sts(input logic [15:0] d);
        step(1);
        wr_en = 1'b1;
        wr_data = d;
        step(1);
        wr_en = 1'b0;
        wr_data = '0;
    endtask

    initial begin
        step(6);
        rst = 1'b0;
        // R1 / R11: no false events although presence, lock and link are asserted
        expect_at(1, 0, 16'hFFFF, 16'h00C0, "R1");
        expect_at(3, 0, 16'hFFFF, 16'h00C0, "R1");
        expect_at(3, 1, 16'hFFFF, 16'h0040, "R12");
        step(5);

        // R2: falling attention input, due after 3 edges
        step(1); attn_n = 1'b0;
        expect_at(2, 0, 16'h0001, 16'h0000, "R2");
        expect_at(3, 0, 16'h0001, 16'h0001, "R2");
        expect_at(4, 1, 16'h00FF, 16'h0040, "R12");
        step(5);
        write_sts(16'h0001);
        expect_at(0, 0, 16'h0001, 16'h0000, "R8");
        // R2: rising edge is ignored
        step(1); attn_n = 1'b1;
        expect_at(3, 0, 16'h0001, 16'h0000, "R2");
        expect_at(5, 0, 16'h0001, 16'h0000, "R2");
        step(6);

        // R3: power fault
        step(1); pfault_n = 1'b0;
        expect_at(2, 0, 16'h0002, 16'h0000, "R3");
        expect_at(3, 0, 16'h0002, 16'h0002, "R3");
        expect_at(4, 1, 16'h00FF, 16'h0040, "R12");
        step(5);
        // R8: writing zeros leaves the flag set
        write_sts(16'h0000);
        expect_at(0, 0, 16'h0002, 16'h0002, "R8");
        write_sts(16'h0002);
        expect_at(0, 0, 16'h0002, 16'h0000, "R8");
        step(2);

        // R4 / R10: latch opens then closes
        step(1); latch_n = 1'b1;
        expect_at(1, 0, 16'h0020, 16'h0000, "R10");
        expect_at(2, 0, 16'h0020, 16'h0020, "R10");
        expect_at(3, 0, 16'h0004, 16'h0004, "R4");
        expect_at(4, 1, 16'h00FF, 16'h0040, "R12");
        step(5);
        write_sts(16'h0004);
        expect_at(0, 0, 16'h0004, 16'h0000, "R4");
        step(1); latch_n = 1'b0;
        expect_at(2, 0, 16'h0020, 16'h0000, "R10");
        expect_at(3, 0, 16'h0004, 16'h0004, "R4");
        step(5);

        // R5 / R10: card removed then inserted
        step(1); pres_n = 1'b1;
        expect_at(2, 0, 16'h0040, 16'h0000, "R10");
        expect_at(3, 0, 16'h0008, 16'h0008, "R5");
        expect_at(4, 1, 16'h0048, 16'h0040, "R12");
        step(5);
        write_sts(16'h0008);
        expect_at(0, 0, 16'h0008, 16'h0000, "R5");
        step(1); pres_n = 1'b0;
        expect_at(2, 0, 16'h0040, 16'h0040, "R10");
        expect_at(3, 0, 16'h0008, 16'h0008, "R5");
        step(5);

        // R10: interlock disengages
        step(1); lock_in = 1'b0;
        expect_at(1, 0, 16'h0080, 16'h0080, "R10");
        expect_at(2, 0, 16'h0080, 16'h0000, "R10");
        step(4);

        // R6: command completed pulse
        step(1); cmd_done = 1'b1;
        expect_at(0, 0, 16'h0010, 16'h0000, "R6");
        expect_at(1, 0, 16'h0010, 16'h0010, "R6");
        expect_at(1, 1, 16'h0010, 16'h0000, "R12");
        step(1); cmd_done = 1'b0;
        step(3);

        // R7: link drops then returns
        step(1); link_up = 1'b0;
        expect_at(1, 0, 16'h0100, 16'h0100, "R7");
        expect_at(1, 1, 16'h0100, 16'h0100, "R7");
        step(3);
        write_sts(16'h0100);
        expect_at(0, 0, 16'h0100, 16'h0000, "R7");
        step(1); link_up = 1'b1;
        expect_at(1, 0, 16'h0100, 16'h0100, "R7");
        step(3);

        // R9: event and clear in the same cycle
        step(1); link_up = 1'b0; wr_en = 1'b1; wr_data = 16'h0110; cmd_done = 1'b1;
        expect_at(1, 0, 16'h0110, 16'h0110, "R9");
        step(1); wr_en = 1'b0; wr_data = '0; cmd_done = 1'b0;
        step(2);
        write_sts(16'h0010);
        expect_at(0, 0, 16'h0110, 16'h0100, "R8");

        // R11: write all ones clears every flag, upper bits stay zero
        write_sts(16'hFFFF);
        expect_at(0, 0, 16'hFE00, 16'h0000, "R11");
        expect_at(0, 0, 16'h011F, 16'h0000, "R8");
        expect_at(0, 1, 16'hFFFF, 16'h0040, "R12");
        step(4);

        if (q.size() != 0) begin
            errors += q.size();
            $display("FAIL pending: %0d expectations never compared (expected 0)", q.size());
        end
        if (!done) begin
            done = 1'b1;
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    initial begin
        #(CLK_PERIOD * 50000);
        if (!done) begin
            done = 1'b1;
            errors++;
            $display("FAIL watchdog: run hung at cycle %0d (expected completion)", cyc);
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

endmodule